// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write Guard

This block sits between a processor and a static RAM and gates the RAM chip-enable, which is active low. While the supply is healthy, the processor's enable reaches the memory through a purely combinational path, so the guard adds no clock-cycle delay. When the supply-good flag drops, the guard write-protects the memory. It does this without cutting off an access that is already under way.

The guard first passes the supply flag through a synchroniser, and only then lets the flag affect its state. The block then decides what to do from the enable it samples at the detection edge:

- **Enable active:** the access may run on until the processor releases the enable, or until a hold limit runs out.
- **Enable idle:** the output is forced inactive at once, which is well within a bounded disable latency.

Once protection is in force, the memory enable stays off. Protection lifts only after the supply flag has stayed good for a set run of cycles and the processor enable is idle. Reset places the guard in the protected state, so power-up goes through the same release path.

Top module: `pfg_ce_guard`

## Requirements
- R1: In the pass state, `ceo_n` equals `cei_n` within the same clock cycle, with no register in the path.
- R2: A drop of `vcc_ok` acts on the state only at the (SYNC_STAGES+1)-th rising edge counted from the first edge that samples it low. Until then `ceo_n` keeps following `cei_n`.
- R3: If `cei_n` is 0 at the detection edge, the guard enters a hold state. In hold, `ceo_n` follows `cei_n`, so the access continues, and the first edge that samples `cei_n` at 1 ends the hold and enters protection.
- R4: A hold lasts at most HOLD_CYC cycles. After that, protection starts even if `cei_n` is still 0.
- R5: If `cei_n` is 1 at the detection edge, `ceo_n` is forced to 1 from that edge on. This lies within DIS_CYC cycles of detection.
- R6: In the protected state, `ceo_n` is 1 whatever `cei_n` does. In every state, `ceo_n` is 0 only while `cei_n` is 0.
- R7: Protection is released only after the synchronised `vcc_ok` has been 1 on REC_CYC consecutive edges. Release happens at edge SYNC_STAGES+REC_CYC+1 counted from the first edge that samples `vcc_ok` high. Any low sample restarts the count.
- R8: Release takes place only at an edge where `cei_n` is 1. While `cei_n` stays 0, the guard stays protected, even after the count is complete.
- R9: During reset and after it, the guard is in the protected state (`ceo_n` = 1), and it leaves that state only through the R7/R8 release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vcc_ok | input | 1 | Supply-good flag, asynchronous to `clk` |
| cei_n | input | 1 | Chip-enable from the processor, active low |
| ceo_n | output | 1 | Gated chip-enable to the memory, active low |

## Verification
Pass-through results are due in the same cycle as the enable change. A supply drop affects the output starting from the (SYNC_STAGES+1)-th edge after the first low sample. A hold ends at the edge that sees the enable released, or HOLD_CYC edges after it began. Release falls on edge SYNC_STAGES+REC_CYC+1 after the supply returns. The driver changes inputs on the falling clock edge, and the monitor samples `ceo_n` 4 ns later, just before the next rising edge. Each queued expectation is therefore written against the edge count above for the cycle it belongs to. Boundary samples are taken one cycle before and one cycle after each of these edges.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [1:0] {
    GS_PASS = 2'd0,
    GS_HOLD = 2'd1,
    GS_PROT = 2'd2
  } guard_st_e;

  // counter width able to hold 0..lim
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

  // memory enable as seen by the RAM for a given state
  function automatic logic gate_ce(input guard_st_e st, input logic cei_n);
    return (st == GS_PROT) ? 1'b1 : cei_n;
  endfunction

  // next state of the guard
  function automatic guard_st_e guard_next(input guard_st_e st, input logic fail,
                                           input logic cei_n, input logic hold_last,
                                           input logic rec_done);
    guard_st_e nx;
    nx = st;
    case (st)
      GS_PASS: if (fail) nx = cei_n ? GS_PROT : GS_HOLD;
      GS_HOLD: if (cei_n || hold_last) nx = GS_PROT;
      GS_PROT: if (rec_done && cei_n) nx = GS_PASS;
      default: nx = GS_PROT;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pfg_count.sv
module pfg_count #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_lim
);
  localparam logic [W-1:0] LIM_W = W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr)                   cnt <= '0;
    else if (inc && cnt != LIM_W)   cnt <= cnt + W'(1);
  end

  assign at_lim = (cnt == LIM_W);

  // limit is reached only by counting, never straight out of a clear (serves R4, R7)
  assert_lim_by_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(at_lim) && LIMIT > 0) |-> ($past(inc) && !$past(clr)));
endmodule

// File: rtl/pfg_fsm.sv
module pfg_fsm
  import pfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fail,
  input  logic      cei_n,
  input  logic      hold_last,
  input  logic      rec_done,
  output guard_st_e st
);
  guard_st_e st_nx;

  always_comb st_nx = guard_next(st, fail, cei_n, hold_last, rec_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= GS_PROT;   // R9: start protected
    else        st <= st_nx;
  end

  // hold is entered only for an access that was active at detection
  assert_hold_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_HOLD && $past(st) == GS_PASS) |-> ($past(!cei_n) && $past(fail)));

  // release happens only on an idle enable
  assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_PASS && $past(st) == GS_PROT) |-> $past(cei_n));

  // release needs a completed recovery count
  assert_release_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_PASS && $past(st) != GS_PASS) |-> $past(rec_done));

  // hold never returns straight to pass
  assert_hold_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == GS_HOLD) |-> (st != GS_PASS));
endmodule

// File: rtl/pfg_ce_guard.sv
module pfg_ce_guard
  import pfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYC    = 8,
  parameter int unsigned DIS_CYC     = 2,
  parameter int unsigned REC_CYC     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok,
  input  logic cei_n,
  output logic ceo_n
);
  localparam int unsigned HOLD_LIM = (HOLD_CYC > 0) ? HOLD_CYC - 1 : 0;
  localparam int unsigned HOLD_W   = cnt_width(HOLD_LIM);
  localparam int unsigned DIS_LIM  = (DIS_CYC > 0) ? DIS_CYC : 1;
  localparam int unsigned DIS_W    = cnt_width(DIS_LIM);
  localparam int unsigned REC_W    = cnt_width(REC_CYC);

  // named internal events
  logic              vcc_ok_s;
  logic              fail_s;
  logic              hold_last;
  logic              rec_done;
  logic              lat_hit;
  logic [HOLD_W-1:0] hold_cnt;
  logic [REC_W-1:0]  rec_cnt;
  logic [DIS_W-1:0]  lat_cnt;
  guard_st_e         st;

  pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(vcc_ok), .q(vcc_ok_s)
  );

  assign fail_s = !vcc_ok_s;

  // hold timeout: at_lim marks the last allowed hold cycle
  pfg_count #(.LIMIT(HOLD_LIM), .W(HOLD_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .clr(st != GS_HOLD), .inc(st == GS_HOLD),
    .cnt(hold_cnt), .at_lim(hold_last)
  );

  // recovery: consecutive good samples while protected
  pfg_count #(.LIMIT(REC_CYC), .W(REC_W)) u_rec (
    .clk(clk), .rst_n(rst_n),
    .clr((st != GS_PROT) || fail_s), .inc(1'b1),
    .cnt(rec_cnt), .at_lim(rec_done)
  );

  // disable latency: cycles a detected failure spends in pass
  pfg_count #(.LIMIT(DIS_LIM), .W(DIS_W)) u_lat (
    .clk(clk), .rst_n(rst_n),
    .clr(!(st == GS_PASS && fail_s)), .inc(1'b1),
    .cnt(lat_cnt), .at_lim(lat_hit)
  );

  pfg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fail(fail_s), .cei_n(cei_n),
    .hold_last(hold_last), .rec_done(rec_done), .st(st)
  );

  // combinational path in pass and hold, forced off when protected
  always_comb ceo_n = gate_ce(st, cei_n);

  // the memory enable is never active unless the processor asks for it
  assert_no_spurious_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ceo_n |-> !cei_n);

  // a held access cannot outlast its budget
  assert_hold_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_HOLD) |-> (hold_cnt <= HOLD_W'(HOLD_LIM)));

  // detected failure leaves pass before the disable latency elapses
  assert_dis_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lat_hit |-> (st != GS_PASS));

  // latency counter only runs after a failure seen in pass
  assert_lat_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_cnt != '0) |-> ($past(fail_s) && $past(st) == GS_PASS));

  // recovery count starts fresh on each protection episode
  assert_rec_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) != GS_PROT) |-> (rec_cnt == '0));

  // a protected guard drops out only when asked by a clean release
  assert_prot_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == GS_PROT && !$past(cei_n)) |-> (st == GS_PROT));
endmodule

// File: tb/pfg_ce_guard_tb.sv
module pfg_ce_guard_tb;
  localparam int unsigned SYNC = 2;
  localparam int unsigned HOLD = 8;
  localparam int unsigned DIS  = 2;
  localparam int unsigned REC  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok = 1'b1;
  logic cei_n = 1'b0;
  logic ceo_n;

  always #5 clk = ~clk;

  pfg_ce_guard #(.SYNC_STAGES(SYNC), .HOLD_CYC(HOLD), .DIS_CYC(DIS), .REC_CYC(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .cei_n(cei_n), .ceo_n(ceo_n)
  );

  // scoreboard: one entry per driven cycle, rid 0 means no compare
  bit exp_q[$];
  int rid_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic step(input logic c, input logic v, input int rid, input bit e);
    @(negedge clk);
    cei_n  = c;
    vcc_ok = v;
    exp_q.push_back(e);
    rid_q.push_back(rid);
  endtask

  // supply returns with idle enable; release lands at step a+REC+2, seen at a+REC+3
  task automatic recover();
    for (int i = 0; i < int'(REC) + 3; i++) step(1'b1, 1'b1, 0, 1'b1);
    step(1'b0, 1'b1, 7, 1'b0);               // R7: pass resumes on time
    step(1'b1, 1'b1, 1, 1'b1);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #4;
      if (rid_q.size() > 0) begin
        int r;
        bit e;
        r = rid_q.pop_front();
        e = exp_q.pop_front();
        if (r > 0) begin
          n_cmp++;
          if (ceo_n !== e) begin
            n_bad++;
            $display("FAIL R%0d: ceo_n=%b expected %b at %0t", r, ceo_n, e, $time);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!finished) begin
      n_bad++;
      $display("FAIL R0: watchdog expired, actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    // R9: protected during reset with an active request
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 9, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: still protected after reset until the recovery count is done
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 9, 1'b1);
    step(1'b1, 1'b1, 0, 1'b1);
    step(1'b0, 1'b1, 7, 1'b0);               // R7: release after reset run

    // R1: same-cycle pass-through over a pattern
    step(1'b1, 1'b1, 1, 1'b1);
    step(1'b0, 1'b1, 1, 1'b0);
    step(1'b1, 1'b1, 1, 1'b1);
    step(1'b1, 1'b1, 1, 1'b1);
    step(1'b0, 1'b1, 1, 1'b0);
    step(1'b1, 1'b1, 1, 1'b1);

    // idle failure
    step(1'b1, 1'b0, 0, 1'b1);
    step(1'b0, 1'b0, 2, 1'b0);               // R2: still passing during sync
    step(1'b1, 1'b0, 2, 1'b1);               // detection edge sees idle enable
    step(1'b0, 1'b0, 5, 1'b1);               // R5: forced off right after detection
    step(1'b1, 1'b0, 6, 1'b1);
    step(1'b0, 1'b0, 6, 1'b1);               // R6: ignores requests
    step(1'b0, 1'b0, 6, 1'b1);
    // R8: supply back but enable held active, release must wait
    for (int i = 0; i < int'(REC) + 6; i++) step(1'b0, 1'b1, 8, 1'b1);
    step(1'b1, 1'b1, 0, 1'b1);
    step(1'b0, 1'b1, 8, 1'b0);               // R8: released once idle
    step(1'b1, 1'b1, 1, 1'b1);

    // exact release timing
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 0, 1'b1);
    recover();

    // short good run broken by a dip restarts the count
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 0, 1'b1);
    step(1'b1, 1'b1, 0, 1'b1);
    step(1'b1, 1'b1, 0, 1'b1);
    step(1'b1, 1'b0, 0, 1'b1);
    for (int i = 0; i < int'(REC) + 1; i++) step(1'b1, 1'b1, 0, 1'b1);
    step(1'b0, 1'b1, 7, 1'b1);               // R7: dip restarted count, not yet
    step(1'b1, 1'b1, 0, 1'b1);
    step(1'b0, 1'b1, 7, 1'b0);               // R7: release after restarted count
    step(1'b1, 1'b1, 1, 1'b1);

    // active access at failure, ended by the processor
    step(1'b0, 1'b1, 1, 1'b0);
    step(1'b0, 1'b0, 2, 1'b0);
    step(1'b0, 1'b0, 2, 1'b0);
    step(1'b0, 1'b0, 3, 1'b0);               // detection edge sees active enable
    step(1'b0, 1'b0, 3, 1'b0);               // R3: access held
    step(1'b0, 1'b0, 3, 1'b0);
    step(1'b1, 1'b0, 3, 1'b1);               // R3: release ends hold
    step(1'b0, 1'b0, 6, 1'b1);               // R6: protected after hold
    step(1'b0, 1'b0, 6, 1'b1);
    recover();

    // active access at failure, never released: timeout
    step(1'b0, 1'b1, 1, 1'b0);
    step(1'b0, 1'b0, 2, 1'b0);
    step(1'b0, 1'b0, 2, 1'b0);
    step(1'b0, 1'b0, 3, 1'b0);
    for (int i = 0; i < int'(HOLD); i++) step(1'b0, 1'b0, 4, 1'b0);   // R4: within budget
    step(1'b0, 1'b0, 4, 1'b1);               // R4: timeout forces off
    step(1'b0, 1'b0, 6, 1'b1);
    recover();

    @(negedge clk);
    #6;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule